// File: doc/BRIEF.md
# Nested Guest Page Walk Controller

This block walks a four-level guest page hierarchy for one guest linear address. Each guest paging-structure entry lives at a guest-physical address. Before the entry can be read, that address has to be turned into a host address by a separate second-level translation unit. The controller starts a walk on a one-cycle `start` pulse, taking the linear address and the guest root pointer. For each level it then asks the translation unit for the entry address, reads the entry from memory at the translated address and decodes it. The walk either descends, finishes, or stops.

A walk ends with a one-cycle result pulse of one of four kinds:

| Code | Result |
|------|--------|
| 0 | Final guest-physical address |
| 1 | Guest page fault, with an error code |
| 2 | Nested exit caused by a translation violation |
| 3 | Nested exit caused by a translation misconfiguration |

A nested failure always takes precedence. When the translation of an entry address fails, that entry is never read and no guest fault is raised. The result also reports the level at which the walk stopped. Level 3 is the root table, indexed by linear-address bits 47:39. Level 0 is the last table, indexed by bits 20:12.

Top module: `gw_nested_walk`

## Requirements
- R1: A `start` pulse while idle begins a walk. In the next cycle `xlat_req` asks for the translation of the first entry address, which is {`groot`[51:12], `gla`[47:39], 3'b000}.
- R2: An entry is read only after its address has been translated successfully (`xlat_status` 0). `mem_rd_req` rises in the cycle after the `xlat_done` pulse, and `mem_rd_addr` equals the returned `xlat_hpa`.
- R3: Only one translation request is outstanding at a time. `xlat_req` lasts one cycle. After it, neither `xlat_req` nor `mem_rd_req` is raised until `xlat_done` arrives.
- R4: If a translation returns status 1, the walk ends with kind 2. If it returns status 2 or 3, the walk ends with kind 3. In both cases `res_level` is the current level, `res_gpa` is the entry address that failed, `res_code` is 0, and no entry read is made for that level.
- R5: A read entry whose bit 0 (present) is 0 ends the walk with kind 1 and error code 4'b0000. `res_gpa` is the entry address and `res_level` is the current level.
- R6: A present entry with a reserved bit set ends the walk with kind 1 and error code 4'b1001 (bit 0 is the present value, bit 3 flags the reserved-bit violation). The reserved bits are bits 62:52 at every level, bit 7 at levels 3 and 2, and bits 20:13 at level 1 when bit 7 is set.
- R7: A valid entry at level 0 ends the walk with kind 0 and address {entry[51:12], `gla`[11:0]}. A valid level-1 entry with bit 7 set ends the walk with kind 0 and address {entry[51:21], `gla`[20:0]}. `res_level` is the leaf level.
- R8: Any other valid entry makes the walk descend one level. The next translation request carries {entry[51:12], next index, 3'b000}, where the next index is the linear-address field of the lower level.
- R9: A `start` pulse while `busy` is high is ignored. The running walk keeps its address and root pointer.
- R10: `res_valid` is a one-cycle pulse, and `busy` is low in the same cycle. A new walk may start from that cycle on.
- R11: After reset, `busy`, `res_valid`, `xlat_req` and `mem_rd_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a walk |
| gla | input | 48 | Guest linear address |
| groot | input | 52 | Guest root pointer; bits 11:0 are ignored |
| xlat_req | output | 1 | One-cycle request to the second-level translator |
| xlat_gpa | output | 52 | Guest-physical entry address to translate |
| xlat_done | input | 1 | Translation response pulse |
| xlat_status | input | 2 | 0 success, 1 violation, 2 or 3 misconfiguration |
| xlat_hpa | input | 52 | Translated host address |
| mem_rd_req | output | 1 | One-cycle entry read request |
| mem_rd_addr | output | 52 | Host address of the entry |
| mem_rd_valid | input | 1 | Read data pulse |
| mem_rd_data | input | 64 | Entry value |
| busy | output | 1 | Walk in progress |
| res_valid | output | 1 | One-cycle result pulse |
| res_kind | output | 2 | 0 final, 1 guest fault, 2 nested violation, 3 nested misconfiguration |
| res_level | output | 2 | Level at which the walk ended |
| res_gpa | output | 52 | Final address, or the entry address that faulted or failed |
| res_code | output | 4 | Guest fault error code |

## Verification
Random walks draw the per-level translation status, the present bit, reserved-bit injection and the page-size bit independently, with random response latencies. This separates a failed translation that pre-empts any guest check from guest faults, and small-page leaves from large-page leaves at level 1. Directed walks pin down each corner on its own: a full four-level descent, a large-page leaf, a violation at the root, status 3 at the last level, a missing entry midway and a reserved gap in a large-page entry. One directed walk pulses `start` with a different address while busy; a result that still matches the first address shows that the pulse was ignored.

// File: rtl/gw_pkg.sv
package gw_pkg;

  // Outcome of one walk, reported on res_kind
  typedef enum logic [1:0] {
    RES_LEAF   = 2'd0,
    RES_GFAULT = 2'd1,
    RES_NVIOL  = 2'd2,
    RES_NMISC  = 2'd3
  } res_kind_e;

  // Response code from the second-level translator
  typedef enum logic [1:0] {
    XS_OK   = 2'd0,
    XS_VIOL = 2'd1,
    XS_MISC = 2'd2,
    XS_RSV  = 2'd3
  } xlat_stat_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XREQ,
    ST_XWAIT,
    ST_MREQ,
    ST_MWAIT
  } walk_st_e;

  localparam int PFC_W     = 4;
  localparam int PFC_P_BIT = 0;
  localparam int PFC_R_BIT = 3;

endpackage

// File: rtl/gw_addr_path.sv
module gw_addr_path #(
  parameter int LA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int PG_SH  = 12,
  parameter int IDX_W  = 9,
  parameter int LVL_W  = 2,
  parameter int ENT_SH = 3
) (
  input  logic [LA_W-1:0]  la,
  input  logic [PA_W-1:0]  root,
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  first_gpa,
  output logic [PA_W-1:0]  next_gpa,
  output logic [PA_W-1:0]  leaf_gpa
);

  localparam int TOP_LVL = (LA_W - PG_SH) / IDX_W - 1;

  // Index field of the linear address used at level lvl
  function automatic logic [IDX_W-1:0] idx_of(input logic [LA_W-1:0] a, input int lvl);
    return IDX_W'(a >> (PG_SH + IDX_W * lvl));
  endfunction

  // Entry address inside a table whose base is taken from b
  function automatic logic [PA_W-1:0] tbl_addr(input logic [PA_W-1:0] b,
                                               input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] base;
    base = b;
    base[PG_SH-1:0] = '0;
    return base | (PA_W'(idx) << ENT_SH);
  endfunction

  // Leaf translation: the offset width grows by one index field per level
  function automatic logic [PA_W-1:0] leaf_addr(input logic [ENT_W-1:0] e,
                                                input logic [LA_W-1:0] a,
                                                input int lvl);
    logic [PA_W-1:0] msk;
    msk = (PA_W'(1) << (PG_SH + IDX_W * lvl)) - PA_W'(1);
    return (e[PA_W-1:0] & ~msk) | (PA_W'(a) & msk);
  endfunction

  int lvl_i;
  int lvl_dn;

  always_comb begin
    lvl_i     = int'(level);
    lvl_dn    = (level == '0) ? 0 : int'(level) - 1;
    first_gpa = tbl_addr(root, idx_of(la, TOP_LVL));
    next_gpa  = tbl_addr(entry[PA_W-1:0], idx_of(la, lvl_dn));
    leaf_gpa  = leaf_addr(entry, la, lvl_i);
  end

endmodule

// File: rtl/gw_entry_check.sv
module gw_entry_check #(
  parameter int ENT_W   = 64,
  parameter int PA_W    = 52,
  parameter int PG_SH   = 12,
  parameter int IDX_W   = 9,
  parameter int LVL_W   = 2,
  parameter int PS_BIT  = 7,
  parameter int DIR_LVL = 1,
  parameter int PFC_W   = 4,
  parameter int P_BIT   = 0,
  parameter int R_BIT   = 3
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] level,
  output logic             present,
  output logic             rsvd,
  output logic             leaf,
  output logic [PFC_W-1:0] pf_code
);

  // Reserved-bit rule per level
  function automatic logic rsvd_of(input logic [ENT_W-1:0] e, input int lvl);
    logic hi;
    logic ps;
    logic gap;
    hi  = |e[ENT_W-2:PA_W];
    ps  = e[PS_BIT];
    gap = |e[PG_SH+IDX_W-1:PG_SH+1];
    if (lvl > DIR_LVL)       return hi | ps;
    else if (lvl == DIR_LVL) return hi | (ps & gap);
    else                     return hi;
  endfunction

  function automatic logic leaf_of(input logic [ENT_W-1:0] e, input int lvl);
    return (lvl == 0) || ((lvl == DIR_LVL) && e[PS_BIT]);
  endfunction

  always_comb begin
    present        = entry[0];
    rsvd           = present & rsvd_of(entry, int'(level));
    leaf           = leaf_of(entry, int'(level));
    pf_code        = '0;
    pf_code[P_BIT] = present;
    pf_code[R_BIT] = rsvd;
  end

endmodule

// File: rtl/gw_walk_seq.sv
module gw_walk_seq
  import gw_pkg::*;
#(
  parameter int LA_W    = 48,
  parameter int PA_W    = 52,
  parameter int LVL_W   = 2,
  parameter int TOP_LVL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LA_W-1:0]  la_in,
  input  logic [PA_W-1:0]  root_in,
  output logic             xlat_req,
  output logic [PA_W-1:0]  xlat_gpa,
  input  logic             xlat_done,
  input  logic [1:0]       xlat_status,
  input  logic [PA_W-1:0]  xlat_hpa,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic             ent_present,
  input  logic             ent_rsvd,
  input  logic             ent_leaf,
  input  logic [PFC_W-1:0] ent_pf_code,
  input  logic [PA_W-1:0]  first_gpa,
  input  logic [PA_W-1:0]  next_gpa,
  input  logic [PA_W-1:0]  leaf_gpa,
  output logic [LA_W-1:0]  la_q,
  output logic [PA_W-1:0]  root_q,
  output logic [LVL_W-1:0] level_q,
  output logic             busy,
  output logic             res_valid,
  output logic [1:0]       res_kind,
  output logic [LVL_W-1:0] res_level,
  output logic [PA_W-1:0]  res_gpa,
  output logic [PFC_W-1:0] res_code
);

  walk_st_e        st_q;
  logic [PA_W-1:0] cur_gpa_q;
  logic [PA_W-1:0] hpa_q;

  // Named events for the assertions
  logic accept_evt;
  logic xlat_ok_evt;
  logic nested_fail_evt;
  logic ent_evt;
  logic fault_evt;
  logic leaf_evt;
  logic descend_evt;

  always_comb begin
    accept_evt      = (st_q == ST_IDLE) && start;
    xlat_ok_evt     = (st_q == ST_XWAIT) && xlat_done && (xlat_status == XS_OK);
    nested_fail_evt = (st_q == ST_XWAIT) && xlat_done && (xlat_status != XS_OK);
    ent_evt         = (st_q == ST_MWAIT) && mem_rd_valid;
    fault_evt       = ent_evt && (!ent_present || ent_rsvd);
    leaf_evt        = ent_evt && ent_present && !ent_rsvd && ent_leaf;
    descend_evt     = ent_evt && ent_present && !ent_rsvd && !ent_leaf;
  end

  assign xlat_req    = (st_q == ST_XREQ);
  assign xlat_gpa    = cur_gpa_q;
  assign mem_rd_req  = (st_q == ST_MREQ);
  assign mem_rd_addr = hpa_q;
  assign busy        = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      la_q      <= '0;
      root_q    <= '0;
      level_q   <= '0;
      cur_gpa_q <= '0;
      hpa_q     <= '0;
      res_valid <= 1'b0;
      res_kind  <= '0;
      res_level <= '0;
      res_gpa   <= '0;
      res_code  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_evt) begin
            la_q      <= la_in;
            root_q    <= root_in;
            level_q   <= LVL_W'(TOP_LVL);
            cur_gpa_q <= first_gpa;
            st_q      <= ST_XREQ;
          end
        end
        ST_XREQ: st_q <= ST_XWAIT;
        ST_XWAIT: begin
          if (xlat_ok_evt) begin
            hpa_q <= xlat_hpa;
            st_q  <= ST_MREQ;
          end else if (nested_fail_evt) begin
            res_valid <= 1'b1;
            res_kind  <= (xlat_status == XS_VIOL) ? RES_NVIOL : RES_NMISC;
            res_level <= level_q;
            res_gpa   <= cur_gpa_q;
            res_code  <= '0;
            st_q      <= ST_IDLE;
          end
        end
        ST_MREQ: st_q <= ST_MWAIT;
        ST_MWAIT: begin
          if (fault_evt) begin
            res_valid <= 1'b1;
            res_kind  <= RES_GFAULT;
            res_level <= level_q;
            res_gpa   <= cur_gpa_q;
            res_code  <= ent_pf_code;
            st_q      <= ST_IDLE;
          end else if (leaf_evt) begin
            res_valid <= 1'b1;
            res_kind  <= RES_LEAF;
            res_level <= level_q;
            res_gpa   <= leaf_gpa;
            res_code  <= '0;
            st_q      <= ST_IDLE;
          end else if (descend_evt) begin
            level_q   <= level_q - 1'b1;
            cur_gpa_q <= next_gpa;
            st_q      <= ST_XREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  read_after_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> $past(xlat_ok_evt));

  // R3
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |=> !xlat_req && !mem_rd_req);

  // R4
  nested_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nested_fail_evt |=> res_valid && (res_kind == RES_NVIOL || res_kind == RES_NMISC));

  // R5
  guest_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> res_valid && (res_kind == RES_GFAULT));

  // R8
  descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    descend_evt |=> xlat_req && (level_q == LVL_W'($past(level_q) - 1'b1)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(la_q) && $stable(root_q));

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy ##1 !res_valid);

endmodule

// File: rtl/gw_nested_walk.sv
module gw_nested_walk
  import gw_pkg::*;
#(
  parameter int LA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int PG_SH  = 12,
  parameter int IDX_W  = 9,
  parameter int ENT_SH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LA_W-1:0]  gla,
  input  logic [PA_W-1:0]  groot,
  output logic             xlat_req,
  output logic [PA_W-1:0]  xlat_gpa,
  input  logic             xlat_done,
  input  logic [1:0]       xlat_status,
  input  logic [PA_W-1:0]  xlat_hpa,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             busy,
  output logic             res_valid,
  output logic [1:0]       res_kind,
  output logic [1:0]       res_level,
  output logic [PA_W-1:0]  res_gpa,
  output logic [3:0]       res_code
);

  localparam int LVLS    = (LA_W - PG_SH) / IDX_W;
  localparam int LVL_W   = $clog2(LVLS);
  localparam int TOP_LVL = LVLS - 1;

  logic [LA_W-1:0]  la_q;
  logic [PA_W-1:0]  root_q;
  logic [LVL_W-1:0] level_q;
  logic [LA_W-1:0]  walk_la;
  logic [PA_W-1:0]  walk_root;
  logic [PA_W-1:0]  first_gpa;
  logic [PA_W-1:0]  next_gpa;
  logic [PA_W-1:0]  leaf_gpa;
  logic             ent_present;
  logic             ent_rsvd;
  logic             ent_leaf;
  logic [PFC_W-1:0] ent_pf_code;

  // While idle the address path sees the incoming request, so the
  // first entry address is ready in the accept cycle.
  assign walk_la   = busy ? la_q : gla;
  assign walk_root = busy ? root_q : groot;

  gw_addr_path #(
    .LA_W(LA_W), .PA_W(PA_W), .ENT_W(ENT_W), .PG_SH(PG_SH),
    .IDX_W(IDX_W), .LVL_W(LVL_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .la       (walk_la),
    .root     (walk_root),
    .entry    (mem_rd_data),
    .level    (level_q),
    .first_gpa(first_gpa),
    .next_gpa (next_gpa),
    .leaf_gpa (leaf_gpa)
  );

  gw_entry_check #(
    .ENT_W(ENT_W), .PA_W(PA_W), .PG_SH(PG_SH), .IDX_W(IDX_W),
    .LVL_W(LVL_W), .PFC_W(PFC_W), .P_BIT(PFC_P_BIT), .R_BIT(PFC_R_BIT)
  ) u_chk (
    .entry  (mem_rd_data),
    .level  (level_q),
    .present(ent_present),
    .rsvd   (ent_rsvd),
    .leaf   (ent_leaf),
    .pf_code(ent_pf_code)
  );

  gw_walk_seq #(
    .LA_W(LA_W), .PA_W(PA_W), .LVL_W(LVL_W), .TOP_LVL(TOP_LVL)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .la_in       (gla),
    .root_in     (groot),
    .xlat_req    (xlat_req),
    .xlat_gpa    (xlat_gpa),
    .xlat_done   (xlat_done),
    .xlat_status (xlat_status),
    .xlat_hpa    (xlat_hpa),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .ent_present (ent_present),
    .ent_rsvd    (ent_rsvd),
    .ent_leaf    (ent_leaf),
    .ent_pf_code (ent_pf_code),
    .first_gpa   (first_gpa),
    .next_gpa    (next_gpa),
    .leaf_gpa    (leaf_gpa),
    .la_q        (la_q),
    .root_q      (root_q),
    .level_q     (level_q),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_kind    (res_kind),
    .res_level   (res_level),
    .res_gpa     (res_gpa),
    .res_code    (res_code)
  );

endmodule

// File: tb/gw_nested_walk_tb.sv
module gw_nested_walk_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [51:0] HPA_XOR = 52'h0_0F0F_0F0F_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] gla = '0;
  logic [51:0] groot = '0;
  logic        xlat_req;
  logic [51:0] xlat_gpa;
  logic        xlat_done = 1'b0;
  logic [1:0]  xlat_status = '0;
  logic [51:0] xlat_hpa = '0;
  logic        mem_rd_req;
  logic [51:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        busy;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [1:0]  res_level;
  logic [51:0] res_gpa;
  logic [3:0]  res_code;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] sc_ent [4];
  logic [1:0]  sc_nst [4];
  bit          sc_poke;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gw_nested_walk u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .gla(gla), .groot(groot),
    .xlat_req(xlat_req), .xlat_gpa(xlat_gpa), .xlat_done(xlat_done),
    .xlat_status(xlat_status), .xlat_hpa(xlat_hpa),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(busy), .res_valid(res_valid), .res_kind(res_kind),
    .res_level(res_level), .res_gpa(res_gpa), .res_code(res_code)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] b_idx(input logic [47:0] a, input int l);
    return a[12 + 9 * l +: 9];
  endfunction

  function automatic logic [51:0] b_xl(input logic [51:0] g);
    return g ^ HPA_XOR;
  endfunction

  function automatic bit b_rsvd(input logic [63:0] e, input int l);
    if (e[62:52] != 0) return 1;
    if (l >= 2 && e[7]) return 1;
    if (l == 1 && e[7] && e[20:13] != 0) return 1;
    return 0;
  endfunction

  task automatic run_walk(input logic [51:0] root, input logic [47:0] la);
    logic [51:0] exp_x [4];
    logic [51:0] g;
    logic [51:0] eg;
    logic [63:0] e;
    logic [1:0]  ek;
    logic [1:0]  el;
    logic [3:0]  ec;
    string       tag;
    int          lvl;
    int          li;
    int          lat;
    bit          fin;
    bit          halt;

    // Expected outcome from the requirements
    g = {root[51:12], b_idx(la, 3), 3'b000};
    ek = 0; el = 0; ec = 0; eg = '0; halt = 0;
    for (int l = 0; l < 4; l++) exp_x[l] = '0;
    for (int l = 3; l >= 0 && !halt; l--) begin
      exp_x[l] = g;
      e = sc_ent[l];
      if (sc_nst[l] != 0) begin
        ek = (sc_nst[l] == 2'd1) ? 2'd2 : 2'd3; el = 2'(l); eg = g; halt = 1;
      end else if (!e[0]) begin
        ek = 2'd1; ec = 4'b0000; el = 2'(l); eg = g; halt = 1;
      end else if (b_rsvd(e, l)) begin
        ek = 2'd1; ec = 4'b1001; el = 2'(l); eg = g; halt = 1;
      end else if (l == 0) begin
        ek = 2'd0; el = 2'(l); eg = {e[51:12], la[11:0]}; halt = 1;
      end else if (l == 1 && e[7]) begin
        ek = 2'd0; el = 2'(l); eg = {e[51:21], la[20:0]}; halt = 1;
      end else begin
        g = {e[51:12], b_idx(la, l - 1), 3'b000};
      end
    end
    tag = (ek >= 2) ? "R4" : (ek == 1) ? ((ec == 4'b1001) ? "R6" : "R5") : "R7";

    @(negedge clk);
    start = 1'b1; gla = la; groot = root;
    @(negedge clk);
    start = 1'b0;
    lvl = 3; fin = 0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      li = (lvl < 0) ? 0 : lvl;
      if (res_valid) begin
        chk(busy == 1'b0, "R10 busy with result", 64'(busy), 64'd0);
        chk(res_kind == ek, {tag, " kind"}, 64'(res_kind), 64'(ek));
        chk(res_level == el, {tag, " level"}, 64'(res_level), 64'(el));
        chk(res_gpa == eg, {tag, " gpa"}, 64'(res_gpa), 64'(eg));
        chk(res_code == ec, {tag, " code"}, 64'(res_code), 64'(ec));
        @(negedge clk);
        chk(!res_valid && !busy && !xlat_req, "R10 pulse/no restart",
            64'({res_valid, busy, xlat_req}), 64'd0);
        fin = 1;
      end else if (xlat_req) begin
        chk(lvl >= 0 && xlat_gpa == exp_x[li], (lvl == 3) ? "R1 first gpa" : "R8 next gpa",
            64'(xlat_gpa), 64'(exp_x[li]));
        lat = 1 + int'($urandom % 3);
        for (int k = 0; k < lat; k++) begin
          if (sc_poke && k == 0) begin start = 1'b1; gla = ~la; groot = ~root; end
          @(negedge clk);
          start = 1'b0;
          chk(!xlat_req && !mem_rd_req && busy, "R3 wait",
              64'({xlat_req, mem_rd_req, busy}), 64'b001);
          if (sc_poke && k == 0) chk(busy, "R9 busy at poke", 64'(busy), 64'd1);
        end
        xlat_done = 1'b1; xlat_status = sc_nst[li]; xlat_hpa = b_xl(exp_x[li]);
        @(negedge clk);
        xlat_done = 1'b0;
      end else if (mem_rd_req) begin
        chk(lvl >= 0 && mem_rd_addr == b_xl(exp_x[li]), "R2 read addr",
            64'(mem_rd_addr), 64'(b_xl(exp_x[li])));
        lat = 1 + int'($urandom % 3);
        repeat (lat) @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = sc_ent[li];
        @(negedge clk);
        mem_rd_valid = 1'b0;
        lvl--;
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) chk(0, "R10 walk did not end", 64'd0, 64'd1);
  endtask

  function automatic logic [63:0] ok_ent();
    logic [63:0] e;
    e = {$urandom, $urandom};
    e[62:52] = '0; e[7] = 1'b0; e[0] = 1'b1;
    return e;
  endfunction

  task automatic clear_sc();
    for (int l = 0; l < 4; l++) begin sc_ent[l] = ok_ent(); sc_nst[l] = 2'd0; end
    sc_poke = 0;
  endtask

  task automatic gen_sc();
    int r;
    for (int l = 0; l < 4; l++) begin
      r = int'($urandom % 40);
      sc_nst[l] = (r == 0) ? 2'd1 : (r == 1) ? 2'd2 : (r == 2) ? 2'd3 : 2'd0;
      sc_ent[l] = ok_ent();
      if ($urandom % 12 == 0) sc_ent[l][0] = 1'b0;
      if (l == 1 && $urandom % 3 == 0) begin
        sc_ent[l][7] = 1'b1;
        sc_ent[l][20:13] = '0;
        if ($urandom % 6 == 0) sc_ent[l][13 + int'($urandom % 8)] = 1'b1;
      end
      if (l >= 2 && $urandom % 15 == 0) sc_ent[l][7] = 1'b1;
      if ($urandom % 14 == 0) sc_ent[l][52 + int'($urandom % 11)] = 1'b1;
    end
    sc_poke = ($urandom % 10 == 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [51:0] rt;
    logic [47:0] la;
    process::self().srandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !res_valid && !xlat_req && !mem_rd_req, "R11 reset",
        64'({busy, res_valid, xlat_req, mem_rd_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid, "R11 after release", 64'({busy, res_valid}), 64'd0);

    rt = 52'h0_1234_5678_9000; la = 48'h7FAB_CDEF_1234;
    // R8/R7 full four-level descent, small page
    clear_sc(); run_walk(rt, la);
    // R7 large page at level 1
    clear_sc(); sc_ent[1][7] = 1'b1; sc_ent[1][20:13] = '0; run_walk(rt, la);
    // R4 violation at the root
    clear_sc(); sc_nst[3] = 2'd1; run_walk(rt, la);
    // R4 status 3 at the last level counts as misconfiguration
    clear_sc(); sc_nst[0] = 2'd3; run_walk(rt, la);
    // R4 failure pre-empts a not-present entry at the same level
    clear_sc(); sc_nst[2] = 2'd2; sc_ent[2][0] = 1'b0; run_walk(rt, la);
    // R5 not present at level 2
    clear_sc(); sc_ent[2][0] = 1'b0; run_walk(rt, la);
    // R6 reserved gap in a large-page entry
    clear_sc(); sc_ent[1][7] = 1'b1; sc_ent[1][20:13] = 8'h10; run_walk(rt, la);
    // R6 page-size bit at level 3 is reserved
    clear_sc(); sc_ent[3][7] = 1'b1; run_walk(rt, la);
    // R6 high reserved bit at level 0
    clear_sc(); sc_ent[0][62] = 1'b1; run_walk(rt, la);
    // R9 start while busy is ignored
    clear_sc(); sc_poke = 1; run_walk(rt, la);

    for (int n = 0; n < 400; n++) begin
      rt = {$urandom, $urandom};
      la = {$urandom, $urandom};
      gen_sc();
      run_walk(rt, la);
    end
    finish_run();
  end

endmodule